// File: doc/BRIEF.md
# Modem Control and Status Register

This block sits beside a serial port and handles its modem handshake lines. Four active-low modem inputs (clear-to-send, data-set-ready, ring indicator, carrier detect) pass through a synchronizer. The block reports their inverted levels to the CPU, together with sticky change flags. It also holds a small control register that drives four active-low outputs: data-terminal-ready, request-to-send and two user outputs.

The CPU reaches the block through a one-bit register select and single-cycle read and write strobes on an 8-bit bus. Select 0 is the control register and select 1 is the status register. Reading the status register clears the change flags. An external enable input gates the interrupt request, which is high while any change flag is set. A loop bit in the control register parks all four outputs at their inactive level so that the line can be isolated for diagnostics.

Top module: `modem_ctl_stat`

## Requirements
- R1: Status bits 7, 6, 5 and 4 read as the inverse of the synchronized carrier-detect, ring, data-set-ready and clear-to-send inputs.
- R2: Status bits 0, 1 and 3 set when the synchronized clear-to-send, data-set-ready or carrier-detect input changes level in either direction.
- R3: Status bit 2 sets only when the synchronized ring input returns from low to high; the high-to-low transition leaves it clear.
- R4: A set change flag stays set until a read strobe at select 1, and that read returns the flags before clearing them.
- R5: A change detected in the same cycle as a status read is latched after the read and is not lost.
- R6: The interrupt request is high exactly when the enable input is high and at least one change flag is set.
- R7: A write at select 0 stores data bits 4..0. Control bits 0, 1, 2 and 3 set to 1 drive data-terminal-ready, request-to-send, user output 1 and user output 2 low. A read at select 0 returns the stored bits with bits 7..5 as zero. A write at select 1 has no effect.
- R8: While control bit 4 (loop) is 1, all four modem outputs are high, whatever bits 3..0 hold.
- R9: Reset clears the control register and all change flags, drives all outputs high, and loads the synchronizer with the inactive (high) level.
- R10: A pin change appears in the status level bits on the second rising edge after it is applied, and its change flag appears on the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| msi_en | input | 1 | Modem-status interrupt enable |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready, active low, asynchronous |
| ri_n | input | 1 | Ring indicator, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect, active low, asynchronous |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| rts_n | output | 1 | Request-to-send, active low |
| out1_n | output | 1 | User output 1, active low |
| out2_n | output | 1 | User output 2, active low |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The assertions assume that a read strobe lasts one cycle and is decoded together with the select in that same cycle. They also assume that reset is held low from time zero until it is released on a falling clock edge. The stimulus changes every input, including the modem pins, only on falling edges, so the synchronizer never sees a mid-cycle change. Strobes, select, data and pins are drawn freshly each cycle. This lets a status read land in the same cycle as a newly detected change.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int unsigned MDM_IN_W   = 4;   // dcd, ri, dsr, cts (msb..lsb)
  localparam int unsigned CTL_W      = 5;   // loop + four line controls
  localparam int unsigned LOOP_BIT   = 4;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned SYNC_DEPTH = 2;
  localparam logic        SEL_CTL    = 1'b0;
  localparam logic        SEL_STS    = 1'b1;
  // bit set: flag only on a low-to-high pin transition (ring trailing edge)
  localparam logic [MDM_IN_W-1:0] TRAIL_ONLY = 4'b0100;

  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mdm_pins_t;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int unsigned    W       = 4,
  parameter int unsigned    STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stage_d[s] = d;
    end else begin : g_next
      always_comb stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= RST_VAL;
      end else begin
        stage_q[s] <= stage_d[s];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/modem_delta.sv
module modem_delta #(
  parameter int unsigned  W          = 4,
  parameter logic [W-1:0] TRAIL_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic         clr,
  output logic [W-1:0] chg,
  output logic [W-1:0] flags
);
  logic [W-1:0] prev_q;
  logic [W-1:0] flags_q;
  logic [W-1:0] flags_d;
  logic         flags_en;

  for (genvar i = 0; i < W; i++) begin : g_det
    if (TRAIL_MASK[i]) begin : g_trail
      always_comb chg[i] = ~prev_q[i] & cur[i];
    end else begin : g_any
      always_comb chg[i] = prev_q[i] ^ cur[i];
    end
  end

  always_comb begin
    flags_en = clr | (|chg);
    flags_d  = (clr ? '0 : flags_q) | chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
    end else begin
      prev_q <= cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  assign flags = flags_q;
endmodule

// File: rtl/modem_ctrl.sv
module modem_ctrl #(
  parameter int unsigned CW       = 5,
  parameter int unsigned LOOP_POS = 4,
  localparam int unsigned NOUT    = LOOP_POS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [CW-1:0]   wd,
  output logic [CW-1:0]   ctrl,
  output logic            loop_on,
  output logic [NOUT-1:0] out_n
);
  logic [CW-1:0] ctrl_q;
  logic [CW-1:0] ctrl_d;

  always_comb ctrl_d = wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign loop_on = ctrl_q[LOOP_POS];

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    always_comb out_n[i] = ~(ctrl_q[i] & ~loop_on);
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
  import modem_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              msi_en,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              dcd_n,
  output logic              dtr_n,
  output logic              rts_n,
  output logic              out1_n,
  output logic              out2_n,
  output logic              irq
);
  localparam int unsigned PAD_W = DATA_W - CTL_W;

  mdm_pins_t             pins_raw;
  logic [MDM_IN_W-1:0]   pins_sync;
  logic [MDM_IN_W-1:0]   chg;
  logic [MDM_IN_W-1:0]   flags;
  logic [CTL_W-1:0]      ctrl_q;
  logic                  loop_on;
  logic [LOOP_BIT-1:0]   line_n;
  logic                  rd_sts;
  logic                  wr_ctl;
  logic [PAD_W-1:0]      unused_wd_hi;

  assign pins_raw     = '{dcd: dcd_n, ri: ri_n, dsr: dsr_n, cts: cts_n};
  assign rd_sts       = rd_en & (reg_sel == SEL_STS);
  assign wr_ctl       = wr_en & (reg_sel == SEL_CTL);
  assign unused_wd_hi = wdata[DATA_W-1:CTL_W];

  modem_sync #(
    .W       (MDM_IN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({MDM_IN_W{1'b1}})
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_raw),
    .q     (pins_sync)
  );

  modem_delta #(
    .W          (MDM_IN_W),
    .TRAIL_MASK (TRAIL_ONLY)
  ) u_delta (
    .clk   (clk),
    .rst_n (rst_n),
    .cur   (pins_sync),
    .clr   (rd_sts),
    .chg   (chg),
    .flags (flags)
  );

  modem_ctrl #(
    .CW       (CTL_W),
    .LOOP_POS (LOOP_BIT)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr_ctl),
    .wd      (wdata[CTL_W-1:0]),
    .ctrl    (ctrl_q),
    .loop_on (loop_on),
    .out_n   (line_n)
  );

  assign dtr_n  = line_n[0];
  assign rts_n  = line_n[1];
  assign out1_n = line_n[2];
  assign out2_n = line_n[3];

  always_comb begin
    if (reg_sel == SEL_STS) begin
      rdata = {~pins_sync, flags};
    end else begin
      rdata = {{PAD_W{1'b0}}, ctrl_q};
    end
  end

  assign irq = msi_en & (|flags);
endmodule

// File: rtl/modem_chk.sv
module modem_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rd_sts,
  input logic         msi_en,
  input logic         irq,
  input logic         loop_on,
  input logic [3:0]   outs,
  input logic [W-1:0] chg,
  input logic [W-1:0] flags
);
  assert_loop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    loop_on |-> (&outs));

  assert_irq_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !msi_en |-> !irq);

  assert_irq_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_en && (flags != '0)) |-> irq);

  assert_clear_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sts && (chg == '0)) |=> (flags == '0));

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sts |=> ((flags & $past(flags)) == $past(flags)));

  assert_keep_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sts |=> ((flags & $past(chg)) == $past(chg)));

  assert_reset_idle_R9: assert property (@(posedge clk)
    !rst_n |-> ((&outs) && (flags == '0)));
endmodule

bind modem_ctl_stat modem_chk #(.W(modem_pkg::MDM_IN_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_sts  (rd_sts),
  .msi_en  (msi_en),
  .irq     (irq),
  .loop_on (loop_on),
  .outs    ({out2_n, out1_n, rts_n, dtr_n}),
  .chg     (chg),
  .flags   (flags)
);

// File: tb/tb_modem_ctl_stat.sv
`timescale 1ns/1ps
module tb_modem_ctl_stat;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b1, wr_en = 1'b0, rd_en = 1'b0, msi_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [3:0] pin_n = 4'hF;   // [0] cts, [1] dsr, [2] ri, [3] dcd
  logic [7:0] rdata;
  logic       dtr_n, rts_n, out1_n, out2_n, irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  modem_ctl_stat dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .msi_en(msi_en),
    .cts_n(pin_n[0]), .dsr_n(pin_n[1]), .ri_n(pin_n[2]), .dcd_n(pin_n[3]),
    .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n), .irq(irq)
  );

  // behavioural reference: pin history, control value, sticky flags
  logic [4:0] m_ctrl;
  logic [3:0] m_flag;
  logic [3:0] hist[$];

  always @(posedge clk or negedge rst_n) begin
    logic [3:0] ch;
    if (!rst_n) begin
      m_ctrl = '0;
      m_flag = '0;
      hist   = {4'hF, 4'hF, 4'hF};
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (i == 2) ch[i] = !hist[2][i] && hist[1][i];
        else        ch[i] = hist[2][i] != hist[1][i];
      end
      if (rd_en && reg_sel) m_flag = '0;
      m_flag = m_flag | ch;
      if (wr_en && !reg_sel) m_ctrl = wdata[4:0];
      hist.push_front(pin_n);
      void'(hist.pop_back());
    end
  end

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare();
    logic [7:0] exp_rd;
    logic [3:0] exp_o;
    exp_rd = reg_sel ? {~hist[1], m_flag} : {3'b000, m_ctrl};
    check(reg_sel ? "R1 R2 R3 R4 readback" : "R7 readback", rdata, exp_rd);
    check("R6 irq", {7'd0, irq}, {7'd0, msi_en && (m_flag != 0)});
    exp_o = m_ctrl[4] ? 4'hF : ~m_ctrl[3:0];
    check(m_ctrl[4] ? "R8 outputs" : "R7 outputs",
          {4'd0, out2_n, out1_n, rts_n, dtr_n}, {4'd0, exp_o});
  endtask

  task automatic step(input logic s, input logic w, input logic r,
                      input logic [7:0] d, input logic [3:0] p, input logic e);
    @(negedge clk);
    compare();
    reg_sel = s; wr_en = w; rd_en = r; wdata = d; pin_n = p; msi_en = e;
  endtask

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R9 reset state
    check("R9 status after reset", rdata, 8'h00);
    check("R9 outputs after reset", {4'd0, out2_n, out1_n, rts_n, dtr_n}, 8'h0F);
    check("R9 irq after reset", {7'd0, irq}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // R7 control writes
    step(0, 1, 0, 8'h05, 4'hF, 1);
    step(0, 0, 1, 8'h00, 4'hF, 1);
    #1;
    check("R7 outputs for 05", {4'd0, out2_n, out1_n, rts_n, dtr_n}, 8'h0A);
    check("R7 readback 05", rdata, 8'h05);
    step(0, 1, 0, 8'hFA, 4'hF, 1);
    step(0, 0, 0, 8'h00, 4'hF, 1);
    #1;
    check("R7 upper data bits dropped", rdata, 8'h1A);
    check("R8 loop holds outputs high", {4'd0, out2_n, out1_n, rts_n, dtr_n}, 8'h0F);
    step(1, 1, 0, 8'h03, 4'hF, 1);
    step(0, 0, 0, 8'h00, 4'hF, 1);
    #1;
    check("R7 write at select 1 ignored", rdata, 8'h1A);
    step(0, 1, 0, 8'h0F, 4'hF, 1);
    step(0, 1, 0, 8'h00, 4'hF, 1);

    // R10 latency on clear-to-send
    step(1, 0, 0, 8'h00, 4'hE, 1);
    step(1, 0, 0, 8'h00, 4'hE, 1);
    #1; check("R10 level not yet", rdata, 8'h00);
    step(1, 0, 0, 8'h00, 4'hE, 1);
    #1; check("R10 level after two edges", rdata, 8'h10);
    step(1, 0, 0, 8'h00, 4'hE, 1);
    #1; check("R10 R2 flag after three edges", rdata, 8'h11);
    check("R6 irq with flag", {7'd0, irq}, 8'h01);
    step(1, 0, 0, 8'h00, 4'hE, 0);
    #1; check("R6 irq masked", {7'd0, irq}, 8'h00);
    step(1, 0, 1, 8'h00, 4'hE, 1);
    step(1, 0, 0, 8'h00, 4'hE, 1);
    #1; check("R4 flags cleared by read", rdata, 8'h10);

    // R3 ring: leading edge no flag, trailing edge flag
    step(1, 0, 0, 8'h00, 4'hA, 1);
    repeat (3) step(1, 0, 0, 8'h00, 4'hA, 1);
    #1; check("R3 ring falling gives no flag", rdata, 8'h50);
    step(1, 0, 0, 8'h00, 4'hE, 1);
    repeat (3) step(1, 0, 0, 8'h00, 4'hE, 1);
    #1; check("R3 ring trailing edge flag", rdata, 8'h14);
    step(1, 0, 1, 8'h00, 4'hE, 1);

    // R5 change detected in the read cycle is kept
    step(1, 0, 0, 8'h00, 4'h6, 1);
    step(1, 0, 0, 8'h00, 4'h6, 1);
    step(1, 0, 1, 8'h00, 4'h6, 1);
    step(1, 0, 0, 8'h00, 4'h6, 1);
    #1; check("R5 carrier flag survives read", rdata, 8'h98);

    // mixed traffic against the reference model
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[1] & r[2], r[3] & r[4], r[15:8],
           (r[5] ? r[19:16] : pin_n), r[6] | r[7]);
    end
    step(1, 0, 0, 8'h00, pin_n, 1);
    @(negedge clk);
    compare();

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule